// File: doc/BRIEF.md
# Framed Serial Sample Output Port

This block sends 16-bit samples from a converter's digital back end to a host signal processor as a framed serial bit stream. It holds the newest word from each of two parallel sources: a full-resolution final-filter result and a faster, lower-latency intermediate filter result. A select input chooses which of the two goes into the next frame. The block makes its own serial clock at half the input clock rate, an active-low frame sync, and one data bit. The data bit also has an output-enable signal that stands for the pin's high-impedance control.

Every frame lasts 32 serial clock periods. The sample goes out MSB first in the first 16 periods while the frame sync is low. In the other 16 periods the frame sync is high and the data bit is zero. An active-low frame sync input restarts frame timing. Several instances that share the input clock and this input therefore start their frames together. A fall on the input is accepted only after the input has been high for at least two input clocks.

Top module: `serial_frame_tx`

## Requirements
- R1: While `rst_n` is low, `sclk` is 0, `fsync_out_n` is 1 and `sdata` is 0. The first frame after reset starts at the first clock edge after release and carries the word 0x0000.
- R2: `sclk` toggles on every `clk` rising edge unless a restart holds it high. `fsync_out_n` and `sdata` change only on edges where `sclk` goes high, so they are stable across each falling `sclk` transition.
- R3: A frame is 32 `sclk` periods (64 `clk` cycles). `fsync_out_n` is 0 for the first 16 periods and 1 for the last 16.
- R4: During the 16 low periods of `fsync_out_n`, `sdata` carries the loaded word from bit 15 down to bit 0, one bit per `sclk` period. While `fsync_out_n` is 1, `sdata` is 0.
- R5: `src_sel` is sampled on the edge that opens a frame. A value of 0 sends the final-filter word (`fin_data`) and a value of 1 sends the intermediate word (`mid_data`).
- R6: A word strobed in by its valid input at any point in a frame is held and sent in the next frame. A strobe on the very edge that opens a frame goes into the frame after that one.
- R7: If a source has had no new strobe since its last word, the frame opened with that source selected sends the same word again. Data on a source without its valid strobe has no effect.
- R8: `sdata_oe` equals `dout_en` with no clock delay. `dout_en` does not change the bit value shown on `sdata`.
- R9: A fall of `fsync_in_n` is accepted after `fsync_in_n` has been sampled high on at least two consecutive `clk` edges. If `fsync_in_n` falls before edge E0, a new full frame starts at edge E1, the next rising edge after E0. From E1 on, `fsync_out_n` is 0 and `sclk` is 1.
- R10: A low on `fsync_in_n` that follows fewer than two high samples is ignored, and the current frame keeps its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fin_data | input | 16 | Final-filter sample word |
| fin_valid | input | 1 | Strobe that captures `fin_data` |
| mid_data | input | 16 | Intermediate-filter sample word |
| mid_valid | input | 1 | Strobe that captures `mid_data` |
| src_sel | input | 1 | Source choice: 0 selects the final word, 1 selects the intermediate word |
| dout_en | input | 1 | Data driver enable |
| fsync_in_n | input | 1 | Active-low frame restart request |
| sclk | output | 1 | Serial clock, `clk`/2 |
| fsync_out_n | output | 1 | Active-low frame sync, low during data |
| sdata | output | 1 | Serial data bit, MSB first |
| sdata_oe | output | 1 | Drive enable for `sdata`; 0 means high impedance |

## Verification
If the bit counter is wrong, the frame sync low or high time is no longer 32 `clk` cycles, and this shows within one frame. If the shift register goes wrong, the data bits are corrupt or nonzero bits appear in the tail, and this shows in the next 16 bit periods. If the restart qualifier goes wrong, a restart either comes late or comes on a short pulse. This shows at `fsync_out_n` within two clock edges, or as a frame of the wrong length. Errors in word hold and selection show up as the wrong word in the frame after the faulty strobe or select.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic {
    SRC_FINAL = 1'b0,
    SRC_MID   = 1'b1
  } src_e;

  // frame length in serial clock periods for a word width
  function automatic int unsigned frame_periods(input int unsigned word_w);
    return 2 * word_w;
  endfunction

  // true while the bit position lies in the data half of the frame
  function automatic logic in_data_half(input int unsigned bitpos,
                                        input int unsigned word_w);
    return bitpos < word_w;
  endfunction

endpackage

// File: rtl/ssp_sync_qual.sv
module ssp_sync_qual #(
  parameter int GAP = 2,
  localparam int HW = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_in_n,
  output logic accept
);

  logic          q_r;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r    <= 1'b1;
      hi_cnt <= '0;
    end else begin
      q_r <= fsync_in_n;
      if (q_r) begin
        if (hi_cnt != HW'(GAP)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
      end
    end
  end

  assign accept = !q_r && (hi_cnt == HW'(GAP));

endmodule

// File: rtl/ssp_timing.sv
module ssp_timing #(
  parameter int WORD_W = 16,
  localparam int FRAME = 2 * WORD_W,
  localparam int CW = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic          ph,
  output logic [CW-1:0] bitpos,
  output logic          frame_load,
  output logic          bit_adv
);

  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

  logic at_end;

  always_comb begin
    at_end     = !ph && (bitpos == LAST);
    frame_load = restart || at_end;
    bit_adv    = !ph && !frame_load;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= 1'b0;
      bitpos <= LAST;
    end else if (frame_load) begin
      ph     <= 1'b1;
      bitpos <= '0;
    end else begin
      ph <= ~ph;
      if (bit_adv) bitpos <= bitpos + 1'b1;
    end
  end

  // R2: serial clock flips every edge except on a restart
  p_sclk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (ph != $past(ph)));

endmodule

// File: rtl/ssp_src_hold.sv
module ssp_src_hold #(
  parameter int WORD_W = 16,
  parameter int NSRC = 2,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSRC-1:0][WORD_W-1:0]   src_data,
  input  logic [NSRC-1:0]               src_vld,
  input  logic [SW-1:0]                 sel,
  output logic [WORD_W-1:0]             word
);

  logic [NSRC-1:0][WORD_W-1:0] hold;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)          hold[g] <= '0;
      else if (src_vld[g]) hold[g] <= src_data[g];
    end

    // R7: a held word stays put without a strobe
    p_hold_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !src_vld[g] |=> (hold[g] == $past(hold[g])));
    // R6: a strobed word is captured
    p_hold_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      src_vld[g] |=> (hold[g] == $past(src_data[g])));
  end

  assign word = hold[sel];

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [WORD_W-1:0] word_in,
  output logic              bit_o
);

  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)    sh <= '0;
    else if (load) sh <= word_in;
    else if (adv)  sh <= {sh[WORD_W-2:0], 1'b0};
  end

  assign bit_o = sh[WORD_W-1];

  // R4: each advance moves the next lower bit to the output
  p_shift_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (bit_o == $past(sh[WORD_W-2])));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int WORD_W = 16,
  parameter int SYNC_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fin_data,
  input  logic              fin_valid,
  input  logic [WORD_W-1:0] mid_data,
  input  logic              mid_valid,
  input  logic              src_sel,
  input  logic              dout_en,
  input  logic              fsync_in_n,
  output logic              sclk,
  output logic              fsync_out_n,
  output logic              sdata,
  output logic              sdata_oe
);

  import ssp_pkg::*;

  localparam int CW = $clog2(frame_periods(WORD_W));

  logic                    sync_accept;
  logic                    frame_load;
  logic                    bit_adv;
  logic                    ph;
  logic [CW-1:0]           bitpos;
  logic [WORD_W-1:0]       next_word;
  logic [1:0][WORD_W-1:0]  src_bus;
  logic [1:0]              vld_bus;

  assign src_bus[SRC_FINAL] = fin_data;
  assign src_bus[SRC_MID]   = mid_data;
  assign vld_bus[SRC_FINAL] = fin_valid;
  assign vld_bus[SRC_MID]   = mid_valid;

  ssp_sync_qual #(.GAP(SYNC_GAP)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsync_in_n (fsync_in_n),
    .accept     (sync_accept)
  );

  ssp_timing #(.WORD_W(WORD_W)) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (sync_accept),
    .ph         (ph),
    .bitpos     (bitpos),
    .frame_load (frame_load),
    .bit_adv    (bit_adv)
  );

  ssp_src_hold #(.WORD_W(WORD_W), .NSRC(2)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_data (src_bus),
    .src_vld  (vld_bus),
    .sel      (src_sel),
    .word     (next_word)
  );

  ssp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (frame_load),
    .adv     (bit_adv),
    .word_in (next_word),
    .bit_o   (sdata)
  );

  assign sclk        = ph;
  assign fsync_out_n = !in_data_half(32'(bitpos), WORD_W);
  assign sdata_oe    = dout_en;

  // R2: outputs hold still across a falling serial clock
  p_stable_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> ($stable(fsync_out_n) && $stable(sdata)));
  // R4: tail half carries zeros
  p_zero_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_out_n |-> !sdata);
  // R3: every load opens the data half with serial clock high
  p_load_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> (!fsync_out_n && sclk));
  // R9: restart only after two high samples on the input pin
  p_sync_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_accept |-> (!$past(fsync_in_n) && $past(fsync_in_n, 2) && $past(fsync_in_n, 3)));

endmodule

// File: tb/serial_frame_tx_bench.sv
module serial_frame_tx_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] fin_data = '0, mid_data = '0;
  logic         fin_valid = 1'b0, mid_valid = 1'b0;
  logic         src_sel = 1'b0, dout_en = 1'b1, fsync_in_n = 1'b1;
  logic         sclk, fsync_out_n, sdata, sdata_oe;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rst_n(rst_n),
    .fin_data(fin_data), .fin_valid(fin_valid),
    .mid_data(mid_data), .mid_valid(mid_valid),
    .src_sel(src_sel), .dout_en(dout_en), .fsync_in_n(fsync_in_n),
    .sclk(sclk), .fsync_out_n(fsync_out_n), .sdata(sdata), .sdata_oe(sdata_oe)
  );

  // {sel, strobe, fin word, mid word}
  localparam logic [33:0] VEC [6] = '{
    {1'b0, 1'b1, 16'hA5C3, 16'h1234},
    {1'b1, 1'b1, 16'h8001, 16'hFFFF},
    {1'b0, 1'b0, 16'hDEAD, 16'hBEEF},
    {1'b1, 1'b0, 16'hDEAD, 16'hBEEF},
    {1'b0, 1'b1, 16'h0000, 16'h7E81},
    {1'b1, 1'b1, 16'hFFFF, 16'h0001}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_frame_start(output int highs, output int nz);
    highs = 0;
    nz = 0;
    while (fsync_out_n !== 1'b0) begin
      highs++;
      if (sdata !== 1'b0) nz++;
      step();
    end
  endtask

  task automatic capture(output logic [W-1:0] w, output int bad);
    bad = 0;
    for (int i = W - 1; i >= 0; i--) begin
      w[i] = sdata;
      if (fsync_out_n !== 1'b0) bad++;
      step();
      if (fsync_out_n !== 1'b0) bad++;
      step();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog act=hang exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] fh, mh, got, exp;
    int bad, highs, nz, lows;
    logic p_s, p_f, p_d;
    fh = '0;
    mh = '0;

    // R1: reset values
    repeat (3) step();
    chk(sclk === 1'b0 && fsync_out_n === 1'b1 && sdata === 1'b0, "R1 reset outputs",
        {sclk, fsync_out_n, sdata}, 3'b010);
    rst_n = 1'b1;
    wait_frame_start(highs, nz);
    capture(got, bad);
    chk(got === 16'h0000 && bad == 0, "R1 first frame word", got, 16'h0000);

    // R5 R6 R7 R4: table of words, strobed mid-frame
    for (int v = 0; v < 6; v++) begin
      step();
      src_sel   = VEC[v][33];
      fin_data  = VEC[v][31:16];
      mid_data  = VEC[v][15:0];
      fin_valid = VEC[v][32];
      mid_valid = VEC[v][32];
      step();
      fin_valid = 1'b0;
      mid_valid = 1'b0;
      if (VEC[v][32]) begin
        fh = VEC[v][31:16];
        mh = VEC[v][15:0];
      end
      exp = VEC[v][33] ? mh : fh;
      wait_frame_start(highs, nz);
      chk(nz == 0, "R4 tail zero", nz, 0);
      capture(got, bad);
      if (VEC[v][32]) chk(got === exp && bad == 0, "R5 R6 selected word", got, exp);
      else            chk(got === exp && bad == 0, "R7 repeated word", got, exp);
    end

    // R3 R2: frame shape and edge alignment
    wait_frame_start(highs, nz);
    lows = 0;
    p_s = sclk; p_f = fsync_out_n; p_d = sdata;
    bad = 0;
    for (int k = 0; k < 64; k++) begin
      if (k < 32 && fsync_out_n === 1'b0) lows++;
      if (k >= 32 && fsync_out_n !== 1'b1) bad++;
      if (k > 0) begin
        if (sclk === p_s) bad++;
        if (sclk === 1'b0 && (fsync_out_n !== p_f || sdata !== p_d)) bad++;
      end
      p_s = sclk; p_f = fsync_out_n; p_d = sdata;
      step();
    end
    chk(lows == 32, "R3 low half length", lows, 32);
    chk(bad == 0, "R2 clock and edge alignment", bad, 0);
    chk(fsync_out_n === 1'b0, "R3 next frame after 64 clocks", fsync_out_n, 1'b0);

    // R6: strobe on the frame-opening edge goes to the following frame
    capture(got, bad);
    wait_frame_start(highs, nz);
    repeat (63) step();
    src_sel = 1'b0;
    fin_data = 16'h3C3C;
    fin_valid = 1'b1;
    step();
    fin_valid = 1'b0;
    chk(fsync_out_n === 1'b0, "R3 frame opened", fsync_out_n, 1'b0);
    capture(got, bad);
    chk(got === fh, "R6 load-edge strobe not in current frame", got, fh);
    fh = 16'h3C3C;

    // R8: enable pass-through, bit value unaffected
    dout_en = 1'b0;
    #1;
    chk(sdata_oe === 1'b0, "R8 oe low", sdata_oe, 1'b0);
    wait_frame_start(highs, nz);
    capture(got, bad);
    chk(got === 16'h3C3C, "R6 R8 word with driver off", got, 16'h3C3C);
    dout_en = 1'b1;
    #1;
    chk(sdata_oe === 1'b1, "R8 oe high", sdata_oe, 1'b1);

    // R9: accepted restart in the tail
    repeat (3) step();
    fsync_in_n = 1'b0;
    step();
    chk(fsync_out_n === 1'b1, "R9 no restart after one edge", fsync_out_n, 1'b1);
    step();
    chk(fsync_out_n === 1'b0 && sclk === 1'b1, "R9 restart on second edge",
        {fsync_out_n, sclk}, 2'b01);
    lows = 0;
    while (fsync_out_n === 1'b0 && lows < 40) begin
      lows++;
      step();
    end
    chk(lows == 32, "R9 restarted frame length", lows, 32);
    wait_frame_start(highs, nz);
    chk(highs == 32, "R3 high half length", highs, 32);

    // R10: one high sample then low again is ignored
    repeat (4) step();
    fsync_in_n = 1'b1;
    step();
    fsync_in_n = 1'b0;
    lows = 0;
    while (fsync_out_n === 1'b0 && lows < 40) begin
      lows++;
      step();
    end
    chk(lows == 27, "R10 short pulse ignored", lows, 27);
    fsync_in_n = 1'b1;
    repeat (4) step();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule